// File: doc/BRIEF.md
# Migratable Home Request Forwarder

Each shared page carries two home identifiers: a static home that is fixed for the page's lifetime and a dynamic home that can move between nodes. Only the dynamic home keeps the directory state for the page's lines. This per-node block accepts one coherence request per cycle and decides where the request goes. If this node is the page's current dynamic home, the request is served locally. If this node is the page's static home, it uses the dynamic-home location it has on record and forwards the request there. A request that this node itself issues goes straight to the dynamic home it has cached. Any foreign request that reaches this node when it is neither home is sent to the page's static home. Stale requests are therefore re-routed and never rejected, and no global invalidation is needed.

A forwarded request keeps its original requester identifier, so the reply returns straight to the requester. When a reply names the current dynamic home, the stored pointer is overwritten. While the static home is moving a page, requests for that page are held in a small in-order queue. They are released once the new dynamic home is recorded. A bank of saturating per-page counters tracks accepted traffic to guide migration software, and software can clear each counter.

Top module: `home_forwarder`

## Requirements
- R1: When the page's dynamic home equals `self_id`, an accepted request produces `out_action` 0 (serve locally) with `out_dest` = `self_id`.
- R2: When this node is neither the dynamic nor the static home and `req_origin` differs from `self_id`, the output is `out_action` 1 with `out_dest` = the page's static home. `out_origin` equals `req_origin`.
- R3: When this node is the static home but not the dynamic home, and the page is not migrating, the output is `out_action` 2 with `out_dest` = the recorded dynamic home.
- R4: A request with `req_origin` = `self_id` for a page that this node neither owns nor statically homes produces `out_action` 2 toward the cached dynamic home.
- R5: A reply (`rsp_valid`) overwrites the page's cached dynamic home. Later requests use the new value.
- R6: At the static home, requests for a page that is marked migrating (`mig_begin_valid`) are held in arrival order. `req_ready` is 0 while the queue is full. After `mig_end_valid` records the new home, the held requests leave one per cycle in order, routed with the new home. This gives action 0 if the new home is `self_id`.
- R7: Each page's counter increments once per accepted request, including held requests. Held requests are not counted again when released. The counter saturates at its maximum value.
- R8: `clr_valid` zeroes the selected page counter. If a request for the same page is accepted in the same cycle, the counter becomes 1.
- R9: After reset, `out_valid` is 0, `req_ready` is 1 and every counter reads 0.
- R10: A request that is not held produces `out_valid` exactly one cycle after acceptance, with `out_page` and `out_origin` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_id | input | NODE_W | This node's identifier |
| req_valid | input | 1 | Incoming request strobe |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_page | input | PAGE_W | Page of the request |
| req_origin | input | NODE_W | Original requester node |
| out_valid | output | 1 | Routed request valid |
| out_action | output | 2 | 0 local, 1 to static home, 2 to dynamic home |
| out_dest | output | NODE_W | Destination node |
| out_origin | output | NODE_W | Original requester, preserved |
| out_page | output | PAGE_W | Page of the routed request |
| cfg_valid | input | 1 | Install page homes |
| cfg_page | input | PAGE_W | Page to install |
| cfg_static | input | NODE_W | Static home value |
| cfg_dynamic | input | NODE_W | Dynamic home value |
| rsp_valid | input | 1 | Reply naming current dynamic home |
| rsp_page | input | PAGE_W | Page of the reply |
| rsp_home | input | NODE_W | Current dynamic home from the reply |
| mig_begin_valid | input | 1 | Mark page as migrating |
| mig_begin_page | input | PAGE_W | Page being migrated |
| mig_end_valid | input | 1 | Migration finished |
| mig_end_page | input | PAGE_W | Page whose migration finished |
| mig_end_home | input | NODE_W | New dynamic home |
| clr_valid | input | 1 | Clear a traffic counter |
| clr_page | input | PAGE_W | Counter to clear |
| cnt_sel | input | PAGE_W | Counter read select |
| cnt_val | output | CNT_W | Selected counter value |

## Verification
Two of this block's functions can land in the same cycle on the same counter: a software clear and the increment from a newly accepted request. The bench drives `clr_valid` and `req_valid` for one page at the same negative edge and expects the counter to read 1 afterwards, not 0 and not the old value plus one. A second overlap is the release of held requests while new requests are waiting. The bench queues two requests behind a migration, so the queue fills and `req_ready` must drop. It then ends the migration and expects the held requests to come out in order, ahead of any new request, each routed to the new home.

// File: rtl/hfwd_pkg.sv
package hfwd_pkg;
    typedef enum logic [1:0] {
        ACT_LOCAL      = 2'd0,
        ACT_TO_STATIC  = 2'd1,
        ACT_TO_DYNAMIC = 2'd2
    } act_e;
endpackage

// File: rtl/hfwd_route.sv
module hfwd_route
    import hfwd_pkg::*;
#(
    parameter int NODE_W = 4
) (
    input  logic [NODE_W-1:0] self_id,
    input  logic [NODE_W-1:0] origin,
    input  logic [NODE_W-1:0] static_id,
    input  logic [NODE_W-1:0] dyn_id,
    input  logic              in_motion,
    output act_e              act,
    output logic [NODE_W-1:0] dest,
    output logic              hold
);
    always_comb begin
        act  = ACT_TO_STATIC;
        dest = static_id;
        hold = 1'b0;
        if (dyn_id == self_id) begin
            act  = ACT_LOCAL;
            dest = self_id;
        end else if (static_id == self_id) begin
            act  = ACT_TO_DYNAMIC;
            dest = dyn_id;
            hold = in_motion;
        end else if (origin == self_id) begin
            act  = ACT_TO_DYNAMIC;
            dest = dyn_id;
        end
    end
endmodule

// File: rtl/hfwd_hold_q.sv
module hfwd_hold_q #(
    parameter int DEPTH  = 2,
    parameter int PAGE_W = 3,
    parameter int NODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PAGE_W-1:0] push_page,
    input  logic [NODE_W-1:0] push_origin,
    input  logic              pop,
    output logic [PAGE_W-1:0] head_page,
    output logic [NODE_W-1:0] head_origin,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PAGE_W-1:0] page;
        logic [DEPTH-1:0][NODE_W-1:0] orig;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } q_t;

    q_t s_q, s_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.page[s_q.wr] = push_page;
            s_d.orig[s_q.wr] = push_origin;
            s_d.wr           = bump(s_q.wr);
        end
        if (pop) s_d.rd = bump(s_q.rd);
        if (push && !pop) s_d.cnt = s_q.cnt + 1'b1;
        else if (pop && !push) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign head_page   = s_q.page[s_q.rd];
    assign head_origin = s_q.orig[s_q.rd];
    assign empty       = (s_q.cnt == '0);
    assign full        = (s_q.cnt == CNT_W'(DEPTH));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/hfwd_counters.sv
module hfwd_counters #(
    parameter int PAGES  = 8,
    parameter int PAGE_W = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic [PAGE_W-1:0] inc_page,
    input  logic              clr,
    input  logic [PAGE_W-1:0] clr_page,
    input  logic [PAGE_W-1:0] sel,
    output logic [CNT_W-1:0]  val
);
    typedef logic [PAGES-1:0][CNT_W-1:0] bank_t;

    bank_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        for (int i = 0; i < PAGES; i++) begin
            if (clr && clr_page == PAGE_W'(i)) begin
                cnt_d[i] = (inc && inc_page == PAGE_W'(i)) ? CNT_W'(1) : '0;
            end else if (inc && inc_page == PAGE_W'(i) && cnt_q[i] != '1) begin
                cnt_d[i] = cnt_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign val = cnt_q[sel];

    for (genvar g = 0; g < PAGES; g++) begin : g_chk
        p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
            (cnt_q[g] == '1 && !(clr && clr_page == PAGE_W'(g))) |=> cnt_q[g] == '1);
        p_clear_r8: assert property (@(posedge clk) disable iff (rst)
            (clr && clr_page == PAGE_W'(g) && !(inc && inc_page == PAGE_W'(g)))
            |=> cnt_q[g] == '0);
    end
endmodule

// File: rtl/home_forwarder.sv
module home_forwarder
    import hfwd_pkg::*;
#(
    parameter int NODE_W     = 4,
    parameter int PAGES      = 8,
    parameter int CNT_W      = 6,
    parameter int HOLD_DEPTH = 2,
    localparam int PAGE_W    = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NODE_W-1:0] self_id,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [NODE_W-1:0] req_origin,
    output logic              out_valid,
    output logic [1:0]        out_action,
    output logic [NODE_W-1:0] out_dest,
    output logic [NODE_W-1:0] out_origin,
    output logic [PAGE_W-1:0] out_page,
    input  logic              cfg_valid,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [NODE_W-1:0] cfg_static,
    input  logic [NODE_W-1:0] cfg_dynamic,
    input  logic              rsp_valid,
    input  logic [PAGE_W-1:0] rsp_page,
    input  logic [NODE_W-1:0] rsp_home,
    input  logic              mig_begin_valid,
    input  logic [PAGE_W-1:0] mig_begin_page,
    input  logic              mig_end_valid,
    input  logic [PAGE_W-1:0] mig_end_page,
    input  logic [NODE_W-1:0] mig_end_home,
    input  logic              clr_valid,
    input  logic [PAGE_W-1:0] clr_page,
    input  logic [PAGE_W-1:0] cnt_sel,
    output logic [CNT_W-1:0]  cnt_val
);
    typedef struct packed {
        logic [PAGES-1:0][NODE_W-1:0] stat;
        logic [PAGES-1:0][NODE_W-1:0] dyn;
        logic [PAGES-1:0]             moving;
        logic                         ov;
        logic [1:0]                   oact;
        logic [NODE_W-1:0]            odest;
        logic [NODE_W-1:0]            oorig;
        logic [PAGE_W-1:0]            opage;
    } st_t;

    st_t s_q, s_d;

    logic              q_empty, q_full, q_push, q_pop;
    logic [PAGE_W-1:0] q_head_page;
    logic [NODE_W-1:0] q_head_origin;
    logic              drain, accept;
    logic [PAGE_W-1:0] sel_page;
    logic [NODE_W-1:0] sel_origin;
    act_e              r_act;
    logic [NODE_W-1:0] r_dest;
    logic              r_hold;

    assign drain      = !q_empty && !s_q.moving[q_head_page];
    assign req_ready  = !q_full && !drain;
    assign accept     = req_valid && req_ready;
    assign sel_page   = drain ? q_head_page : req_page;
    assign sel_origin = drain ? q_head_origin : req_origin;
    assign q_push     = accept && r_hold;
    assign q_pop      = drain;

    hfwd_route #(.NODE_W(NODE_W)) u_route (
        .self_id   (self_id),
        .origin    (sel_origin),
        .static_id (s_q.stat[sel_page]),
        .dyn_id    (s_q.dyn[sel_page]),
        .in_motion (!drain && s_q.moving[sel_page]),
        .act       (r_act),
        .dest      (r_dest),
        .hold      (r_hold)
    );

    hfwd_hold_q #(.DEPTH(HOLD_DEPTH), .PAGE_W(PAGE_W), .NODE_W(NODE_W)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .push        (q_push),
        .push_page   (req_page),
        .push_origin (req_origin),
        .pop         (q_pop),
        .head_page   (q_head_page),
        .head_origin (q_head_origin),
        .empty       (q_empty),
        .full        (q_full)
    );

    hfwd_counters #(.PAGES(PAGES), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .inc      (accept),
        .inc_page (req_page),
        .clr      (clr_valid),
        .clr_page (clr_page),
        .sel      (cnt_sel),
        .val      (cnt_val)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ov    = drain || (accept && !r_hold);
        s_d.oact  = r_act;
        s_d.odest = r_dest;
        s_d.oorig = sel_origin;
        s_d.opage = sel_page;
        if (rsp_valid) s_d.dyn[rsp_page] = rsp_home;
        if (mig_end_valid) begin
            s_d.dyn[mig_end_page]    = mig_end_home;
            s_d.moving[mig_end_page] = 1'b0;
        end
        if (mig_begin_valid) s_d.moving[mig_begin_page] = 1'b1;
        if (cfg_valid) begin
            s_d.stat[cfg_page]   = cfg_static;
            s_d.dyn[cfg_page]    = cfg_dynamic;
            s_d.moving[cfg_page] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid  = s_q.ov;
    assign out_action = s_q.oact;
    assign out_dest   = s_q.odest;
    assign out_origin = s_q.oorig;
    assign out_page   = s_q.opage;

    p_local_self_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_action == 2'd0) |-> out_dest == self_id);
    p_static_foreign_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_action == 2'd1) |-> out_origin != self_id);
    p_dyn_elsewhere_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_action == 2'd2) |-> out_dest != self_id);
    p_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !r_hold) |=> (out_valid && out_page == $past(req_page)
                                                 && out_origin == $past(req_origin)));
endmodule

// File: tb/home_forwarder_bench.sv
module home_forwarder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int PW = 3;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NW-1:0] self_id = 4'd3;
    logic req_valid = 0, req_ready;
    logic [PW-1:0] req_page = 0;
    logic [NW-1:0] req_origin = 0;
    logic out_valid;
    logic [1:0] out_action;
    logic [NW-1:0] out_dest, out_origin;
    logic [PW-1:0] out_page;
    logic cfg_valid = 0;
    logic [PW-1:0] cfg_page = 0;
    logic [NW-1:0] cfg_static = 0, cfg_dynamic = 0;
    logic rsp_valid = 0;
    logic [PW-1:0] rsp_page = 0;
    logic [NW-1:0] rsp_home = 0;
    logic mig_begin_valid = 0;
    logic [PW-1:0] mig_begin_page = 0;
    logic mig_end_valid = 0;
    logic [PW-1:0] mig_end_page = 0;
    logic [NW-1:0] mig_end_home = 0;
    logic clr_valid = 0;
    logic [PW-1:0] clr_page = 0;
    logic [PW-1:0] cnt_sel = 0;
    logic [CW-1:0] cnt_val;

    always #(CLK_PERIOD / 2) clk = ~clk;

    home_forwarder #(.NODE_W(NW), .PAGES(8), .CNT_W(CW), .HOLD_DEPTH(2)) u_home_forwarder (
        .clk(clk), .rst(rst), .self_id(self_id),
        .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page), .req_origin(req_origin),
        .out_valid(out_valid), .out_action(out_action), .out_dest(out_dest),
        .out_origin(out_origin), .out_page(out_page),
        .cfg_valid(cfg_valid), .cfg_page(cfg_page), .cfg_static(cfg_static), .cfg_dynamic(cfg_dynamic),
        .rsp_valid(rsp_valid), .rsp_page(rsp_page), .rsp_home(rsp_home),
        .mig_begin_valid(mig_begin_valid), .mig_begin_page(mig_begin_page),
        .mig_end_valid(mig_end_valid), .mig_end_page(mig_end_page), .mig_end_home(mig_end_home),
        .clr_valid(clr_valid), .clr_page(clr_page), .cnt_sel(cnt_sel), .cnt_val(cnt_val)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [1:0]    exp_act[$];
    logic [NW-1:0] exp_dest[$];
    logic [NW-1:0] exp_orig[$];
    logic [PW-1:0] exp_page[$];
    string         exp_tag[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per routed output
    always @(negedge clk) begin
        if (!rst && out_valid && !finished) begin
            if (exp_act.size() == 0) begin
                check(1'b0, "R10 unexpected output", int'(out_dest), -1);
            end else begin
                string t;
                t = exp_tag.pop_front();
                check(out_action == exp_act[0], {t, " action"}, int'(out_action), int'(exp_act[0]));
                check(out_dest == exp_dest[0], {t, " dest"}, int'(out_dest), int'(exp_dest[0]));
                check(out_origin == exp_orig[0], {t, " origin"}, int'(out_origin), int'(exp_orig[0]));
                check(out_page == exp_page[0], {t, " page"}, int'(out_page), int'(exp_page[0]));
                void'(exp_act.pop_front());
                void'(exp_dest.pop_front());
                void'(exp_orig.pop_front());
                void'(exp_page.pop_front());
            end
        end
    end

    task automatic expect_out(input int p, input int o, input int a, input int d, input string tag);
        exp_act.push_back(2'(a));
        exp_dest.push_back(NW'(d));
        exp_orig.push_back(NW'(o));
        exp_page.push_back(PW'(p));
        exp_tag.push_back(tag);
    endtask

    task automatic send(input int p, input int o, input int a, input int d, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_page = PW'(p); req_origin = NW'(o);
        expect_out(p, o, a, d, tag);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic cfg(input int p, input int s, input int d);
        @(negedge clk);
        cfg_valid = 1; cfg_page = PW'(p); cfg_static = NW'(s); cfg_dynamic = NW'(d);
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        check(out_valid == 0, "R9 out_valid", int'(out_valid), 0);
        check(req_ready == 1, "R9 req_ready", int'(req_ready), 1);
        check(cnt_val == 0, "R9 counter", int'(cnt_val), 0);

        cfg(0, 3, 3);
        cfg(1, 5, 3);
        cfg(2, 3, 6);
        cfg(3, 5, 7);

        send(0, 9, 0, 3, "R1 page0 local");
        send(1, 3, 0, 3, "R1 page1 local");
        send(2, 9, 2, 6, "R3 static home forwards");
        send(3, 9, 1, 5, "R2 stale to static");
        send(3, 3, 2, 7, "R4 own request direct");
        settle();

        // R5 reply repairs cached home
        @(negedge clk);
        rsp_valid = 1; rsp_page = 3; rsp_home = 2;
        @(negedge clk);
        rsp_valid = 0;
        send(3, 3, 2, 2, "R5 repaired pointer");
        send(3, 9, 1, 5, "R5 foreign still static");
        settle();

        // R6 hold during migration
        @(negedge clk);
        mig_begin_valid = 1; mig_begin_page = 2;
        @(negedge clk);
        mig_begin_valid = 0;
        send(2, 9, 2, 4, "R6 held first");
        send(2, 3, 2, 4, "R6 held second");
        check(req_ready == 0, "R6 ready low when full", int'(req_ready), 0);
        check(out_valid == 0, "R6 nothing emitted while held", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 0, "R6 still held", int'(out_valid), 0);
        mig_end_valid = 1; mig_end_page = 2; mig_end_home = 4;
        @(negedge clk);
        mig_end_valid = 0;
        send(1, 9, 0, 3, "R6 new request after drain");
        settle();

        // R6 migration onto this node
        @(negedge clk);
        mig_begin_valid = 1; mig_begin_page = 2;
        @(negedge clk);
        mig_begin_valid = 0;
        send(2, 9, 0, 3, "R6 held then local");
        @(negedge clk);
        mig_end_valid = 1; mig_end_page = 2; mig_end_home = 3;
        @(negedge clk);
        mig_end_valid = 0;
        settle();

        // R7 counting of held requests, once each
        cnt_sel = 2;
        @(negedge clk);
        check(cnt_val == 4, "R7 page2 count", int'(cnt_val), 4);

        // R7 saturation: page0 had 1, add 8
        for (int i = 0; i < 8; i++) send(0, 9, 0, 3, "R7 fill");
        settle();
        cnt_sel = 0;
        @(negedge clk);
        check(cnt_val == 7, "R7 saturated", int'(cnt_val), 7);

        // R8 plain clear
        clr_valid = 1; clr_page = 0;
        @(negedge clk);
        clr_valid = 0;
        check(cnt_val == 0, "R8 cleared", int'(cnt_val), 0);
        send(0, 9, 0, 3, "R8 count after clear");
        send(0, 9, 0, 3, "R8 count after clear");
        check(cnt_val == 2, "R8 counts again", int'(cnt_val), 2);

        // R8 clear and request in the same cycle
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_page = 0; req_origin = 9;
        clr_valid = 1; clr_page = 0;
        expect_out(0, 9, 0, 3, "R8 collide output");
        @(negedge clk);
        req_valid = 0; clr_valid = 0;
        check(cnt_val == 1, "R8 clear with request", int'(cnt_val), 1);
        settle();

        check(exp_act.size() == 0, "R10 all outputs seen", exp_act.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule